// File: doc/BRIEF.md
# Privileged State Register File

This block holds the privileged and hyper-privileged control state of one processor strand. Software reaches every register through a single indexed access port: an access is presented for one cycle with an index, a write enable and write data, and the old contents of the indexed register come back on the read bus one cycle later. Writes to some registers are shaped on the way in: bits outside a fixed mask are dropped, low address bits are zeroed, and an out-of-range trap level is clamped.

A trap stack keeps five values per trap level (trap PC, trap next PC, saved state, trap type and saved hyper state). The current trap level selects the entry: level N addresses entry N-1, and level 0 has no entry at all. The block also packs a combined translation-context word for the address translation logic, and raises a trap-level-zero interrupt request when software lowers the trap level to zero while running below hyper-privileged mode with the trap-level-zero enable set.

Top module: `priv_state_regfile`

## Requirements
- R1: After reset every register reads zero, except hyper state (index 8), which reads 0x800, and strand status (index 9), which reads 0x50000; `bad_idx`, `tlz_irq` and `rd_data` are zero.
- R2: A write to processor state (index 6) stores the data ANDed with 0x13DE (bits 12, 9..6 and 4..1 kept).
- R3: A write to the trap base address (index 5) stores the data with bits 14..0 forced to zero.
- R4: Indices 0 (trap PC), 1 (trap next PC), 2 (trap saved state), 3 (trap type) and 4 (saved hyper state) access the trap-stack entry for the current trap level; each of the levels 1..MAX_TL (default 6) keeps its own five values.
- R5: While the trap level is 0, reads of indices 0..4 return zero and writes to them change nothing.
- R6: A write to the trap level (index 7) stores the data when it is at most MAX_TL and MAX_TL otherwise; the trap level reads back zero-extended.
- R7: A write to the trap level sets `tlz_irq` on the next cycle when the written data is zero, hyper state bit 0 (trap-level-zero enable) is 1 and hyper state bit 2 (hyper-privileged) is 0; any other trap-level write clears it, and no other access changes it.
- R8: Index 14 reads the packed context word: bit 0 = hyper state bit 2, bit 1 = hyper state bit 5, bits 3:2 = processor state bits 3:2, bits 5:4 = index 13 bits 3:2, bits 15:8 = index 12 bits 7:0, bits 18:16 = trap level, bits 47:32 = index 10 bits 15:0, bits 63:48 = index 11 bits 15:0, all other bits zero; writes to index 14 are ignored.
- R9: Indices 10..13, 16..23 (eight scratch words) and 24..31 (eight queue head/tail words) store and return full 64-bit values.
- R10: An access to index 15 or 32..63 pulses `bad_idx` for one cycle, returns zero and changes no register.
- R11: `rd_data` carries, in the cycle after an access, the register value from before that access's write; in a cycle after no access it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_we | input | 1 | Access is a write |
| acc_idx | input | 6 | Register index |
| acc_wdata | input | 64 | Write data |
| rd_data | output | 64 | Read data, one cycle after the access |
| bad_idx | output | 1 | One-cycle pulse for an unimplemented index |
| tlz_irq | output | 1 | Trap-level-zero interrupt request |

## Verification
Every result of this block is due exactly one clock edge after the access that causes it: read data, the unimplemented-index pulse and the interrupt request are all registered once, and a write becomes visible to an access made in the following cycle. The bench drives each access just after a falling edge, lets the design sample it at the rising edge, and compares all three outputs with its model at the next falling edge, so every cycle is checked. Read-before-write ordering is covered by reading a register in the same cycle as it is written.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int WORD_W = 64;
    localparam int IDX_W  = 6;
    localparam int TS_FIELDS = 5;
    localparam int NUM_SCR = 8;
    localparam int NUM_QUE = 8;

    typedef logic [WORD_W-1:0] word_t;

    // index map
    localparam logic [IDX_W-1:0] IDX_TS_LAST = 6'd4;
    localparam logic [IDX_W-1:0] IDX_TBA     = 6'd5;
    localparam logic [IDX_W-1:0] IDX_PSTATE  = 6'd6;
    localparam logic [IDX_W-1:0] IDX_TL      = 6'd7;
    localparam logic [IDX_W-1:0] IDX_HSTATE  = 6'd8;
    localparam logic [IDX_W-1:0] IDX_STRAND  = 6'd9;
    localparam logic [IDX_W-1:0] IDX_PCTX    = 6'd10;
    localparam logic [IDX_W-1:0] IDX_SCTX    = 6'd11;
    localparam logic [IDX_W-1:0] IDX_PART    = 6'd12;
    localparam logic [IDX_W-1:0] IDX_LSU     = 6'd13;
    localparam logic [IDX_W-1:0] IDX_PACK    = 6'd14;
    localparam logic [IDX_W-1:0] IDX_SCR0    = 6'd16;
    localparam logic [IDX_W-1:0] IDX_QUE0    = 6'd24;

    localparam word_t PSTATE_KEEP  = 64'h0000_0000_0000_13DE;
    localparam int    TBA_LOW_ZERO = 15;
    localparam word_t HSTATE_RST   = 64'h0000_0000_0000_0800;
    localparam word_t STRAND_RST   = 64'h0000_0000_0005_0000;

    localparam int HS_TLZ_BIT  = 0;
    localparam int HS_PRIV_BIT = 2;
    localparam int HS_RED_BIT  = 5;
endpackage

// File: rtl/psr_trap_stack.sv
module psr_trap_stack
    import psr_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int LVL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       fld,
    input  logic [LVL_W-1:0] lvl,
    input  word_t            wdata,
    output word_t            rdata
);
    word_t ent_q [MAX_TL][TS_FIELDS];
    word_t ent_d [MAX_TL][TS_FIELDS];

    always_comb begin
        ent_d = ent_q;
        rdata = '0;
        for (int e = 0; e < MAX_TL; e++) begin
            for (int f = 0; f < TS_FIELDS; f++) begin
                if (lvl == LVL_W'(e + 1) && fld == 3'(f)) begin
                    rdata = ent_q[e][f];
                    if (wr_en) ent_d[e][f] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '{default: '0};
        else        ent_q <= ent_d;
    end
endmodule

// File: rtl/psr_ctx_pack.sv
module psr_ctx_pack
    import psr_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  word_t            hstate,
    input  word_t            pstate,
    input  word_t            lsu,
    input  word_t            part,
    input  word_t            pctx,
    input  word_t            sctx,
    input  logic [LVL_W-1:0] lvl,
    output word_t            packed_ctx
);
    logic [2:0] lvl3;
    assign lvl3 = 3'(lvl);

    always_comb begin
        packed_ctx        = '0;
        packed_ctx[0]     = hstate[HS_PRIV_BIT];
        packed_ctx[1]     = hstate[HS_RED_BIT];
        packed_ctx[3:2]   = pstate[3:2];
        packed_ctx[5:4]   = lsu[3:2];
        packed_ctx[15:8]  = part[7:0];
        packed_ctx[18:16] = lvl3;
        packed_ctx[47:32] = pctx[15:0];
        packed_ctx[63:48] = sctx[15:0];
    end
endmodule

// File: rtl/priv_state_regfile.sv
module priv_state_regfile
    import psr_pkg::*;
#(
    parameter int MAX_TL = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic        acc_we,
    input  logic [5:0]  acc_idx,
    input  logic [63:0] acc_wdata,
    output logic [63:0] rd_data,
    output logic        bad_idx,
    output logic        tlz_irq
);
    localparam int LVL_W = $clog2(MAX_TL + 1);

    typedef struct packed {
        word_t                   tba;
        word_t                   pstate;
        word_t                   hstate;
        word_t                   strand;
        word_t                   pctx;
        word_t                   sctx;
        word_t                   part;
        word_t                   lsu;
        logic [LVL_W-1:0]        lvl;
        logic [NUM_SCR-1:0][WORD_W-1:0] scr;
        logic [NUM_QUE-1:0][WORD_W-1:0] que;
        word_t                   rd;
        logic                    err;
        logic                    irq;
    } st_t;

    st_t   st_q, st_d;
    word_t ts_rdata, packed_ctx, rd_val;
    logic  ts_we;

    psr_trap_stack #(.MAX_TL(MAX_TL), .LVL_W(LVL_W)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ts_we),
        .fld   (acc_idx[2:0]),
        .lvl   (st_q.lvl),
        .wdata (acc_wdata),
        .rdata (ts_rdata)
    );

    psr_ctx_pack #(.LVL_W(LVL_W)) u_pack (
        .hstate     (st_q.hstate),
        .pstate     (st_q.pstate),
        .lsu        (st_q.lsu),
        .part       (st_q.part),
        .pctx       (st_q.pctx),
        .sctx       (st_q.sctx),
        .lvl        (st_q.lvl),
        .packed_ctx (packed_ctx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rd  = '0;
        st_d.err = 1'b0;
        ts_we    = 1'b0;
        rd_val   = '0;
        if (acc_en) begin
            case (acc_idx) inside
                [6'd0:IDX_TS_LAST]: begin
                    rd_val = ts_rdata;
                    ts_we  = acc_we;
                end
                IDX_TBA: begin
                    rd_val = st_q.tba;
                    if (acc_we) st_d.tba = {acc_wdata[WORD_W-1:TBA_LOW_ZERO], {TBA_LOW_ZERO{1'b0}}};
                end
                IDX_PSTATE: begin
                    rd_val = st_q.pstate;
                    if (acc_we) st_d.pstate = acc_wdata & PSTATE_KEEP;
                end
                IDX_TL: begin
                    rd_val = WORD_W'(st_q.lvl);
                    if (acc_we) begin
                        st_d.lvl = (acc_wdata > WORD_W'(MAX_TL)) ? LVL_W'(MAX_TL)
                                                                 : acc_wdata[LVL_W-1:0];
                        st_d.irq = (acc_wdata == '0) && st_q.hstate[HS_TLZ_BIT]
                                   && !st_q.hstate[HS_PRIV_BIT];
                    end
                end
                IDX_HSTATE: begin
                    rd_val = st_q.hstate;
                    if (acc_we) st_d.hstate = acc_wdata;
                end
                IDX_STRAND: begin
                    rd_val = st_q.strand;
                    if (acc_we) st_d.strand = acc_wdata;
                end
                IDX_PCTX: begin
                    rd_val = st_q.pctx;
                    if (acc_we) st_d.pctx = acc_wdata;
                end
                IDX_SCTX: begin
                    rd_val = st_q.sctx;
                    if (acc_we) st_d.sctx = acc_wdata;
                end
                IDX_PART: begin
                    rd_val = st_q.part;
                    if (acc_we) st_d.part = acc_wdata;
                end
                IDX_LSU: begin
                    rd_val = st_q.lsu;
                    if (acc_we) st_d.lsu = acc_wdata;
                end
                IDX_PACK: rd_val = packed_ctx;
                [IDX_SCR0:IDX_SCR0+6'(NUM_SCR-1)]: begin
                    rd_val = st_q.scr[acc_idx[2:0]];
                    if (acc_we) st_d.scr[acc_idx[2:0]] = acc_wdata;
                end
                [IDX_QUE0:IDX_QUE0+6'(NUM_QUE-1)]: begin
                    rd_val = st_q.que[acc_idx[2:0]];
                    if (acc_we) st_d.que[acc_idx[2:0]] = acc_wdata;
                end
                default: st_d.err = 1'b1;
            endcase
            st_d.rd = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.hstate <= HSTATE_RST;
            st_q.strand <= STRAND_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;
    assign bad_idx = st_q.err;
    assign tlz_irq = st_q.irq;
endmodule

// File: rtl/psr_regfile_chk.sv
module psr_regfile_chk
    import psr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_we,
    input logic [5:0]  acc_idx,
    input logic [63:0] acc_wdata,
    input logic [63:0] rd_data,
    input logic        bad_idx,
    input logic        tlz_irq
);
    // R10
    err_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_idx |-> $past(acc_en));

    // R10
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_idx |-> rd_data == '0);

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> (rd_data == '0 && !bad_idx));

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tlz_irq) |-> $past(acc_en && acc_we && acc_idx == IDX_TL && acc_wdata == '0));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && acc_we && acc_idx == IDX_TL) |=> $stable(tlz_irq));

    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && acc_idx == IDX_TL && acc_wdata != '0) |=> !tlz_irq);
endmodule

bind priv_state_regfile psr_regfile_chk u_chk (.*);

// File: tb/priv_state_regfile_bench.sv
module priv_state_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [5:0]  acc_idx = '0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] rd_data;
    logic        bad_idx;
    logic        tlz_irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // behavioural model state
    logic [63:0] m_r [64];
    logic [63:0] m_ts [1:6][5];
    int          m_tl;
    bit          m_irq;

    always #10 clk = ~clk;

    priv_state_regfile u_priv_state_regfile (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_idx(acc_idx), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .bad_idx(bad_idx), .tlz_irq(tlz_irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic bit known(int idx);
        return (idx <= 14) || (idx >= 16 && idx <= 31);
    endfunction

    function automatic logic [63:0] m_read(int idx);
        logic [63:0] v;
        v = 64'd0;
        if (idx <= 4) begin
            if (m_tl > 0) v = m_ts[m_tl][idx];
        end else if (idx == 7) begin
            v = 64'(m_tl);
        end else if (idx == 14) begin
            v[63:48] = m_r[11][15:0];
            v[47:32] = m_r[10][15:0];
            v[18:16] = 3'(m_tl);
            v[15:8]  = m_r[12][7:0];
            v[5:4]   = m_r[13][3:2];
            v[3:2]   = m_r[6][3:2];
            v[1]     = m_r[8][5];
            v[0]     = m_r[8][2];
        end else if (known(idx)) begin
            v = m_r[idx];
        end
        return v;
    endfunction

    task automatic m_write(int idx, logic [63:0] d);
        if (idx <= 4) begin
            if (m_tl > 0) m_ts[m_tl][idx] = d;
        end else if (idx == 5) begin
            m_r[5] = d & ~64'h7FFF;
        end else if (idx == 6) begin
            m_r[6] = d & 64'h13DE;
        end else if (idx == 7) begin
            m_irq = (d == 64'd0) && m_r[8][0] && !m_r[8][2];
            m_tl  = (d > 64'd6) ? 6 : int'(d);
        end else if (idx != 14 && known(idx)) begin
            m_r[idx] = d;
        end
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit en, bit we, int idx, logic [63:0] wd, string tag);
        logic [63:0] e_rd;
        bit          e_err;
        acc_en = en; acc_we = we; acc_idx = 6'(idx); acc_wdata = wd;
        e_rd = 64'd0; e_err = 1'b0;
        if (en) begin
            if (!known(idx)) e_err = 1'b1;
            else e_rd = m_read(idx);
            if (we) m_write(idx, wd);
        end
        @(negedge clk);
        chk({tag, " rd_data"}, rd_data, e_rd);
        chk({tag, " bad_idx"}, 64'(bad_idx), 64'(e_err));
        chk({tag, " tlz_irq"}, 64'(tlz_irq), 64'(m_irq));
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic wr(int idx, logic [63:0] d, string tag);
        step(1'b1, 1'b1, idx, d, tag);
    endtask

    task automatic rd(int idx, string tag);
        step(1'b1, 1'b0, idx, 64'd0, tag);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_r[i] = 64'd0;
        for (int l = 1; l <= 6; l++) for (int f = 0; f < 5; f++) m_ts[l][f] = 64'd0;
        m_r[8] = 64'h800; m_r[9] = 64'h50000; m_tl = 0; m_irq = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, then R11 idle cycle
        step(1'b0, 1'b0, 0, 64'd0, "R11 idle");
        for (int i = 0; i < 32; i++) rd(i, "R1 reset value");

        // R2 processor-state mask
        wr(6, 64'hFFFF_FFFF_FFFF_FFFF, "R2 write");
        rd(6, "R2 masked");
        wr(6, 64'h0000_0000_0000_2C21, "R2 write2");
        rd(6, "R2 masked2");

        // R3 trap base low bits cleared
        wr(5, 64'hFFFF_FFFF_FFFF_FFFF, "R3 write");
        rd(5, "R3 cleared");
        wr(5, 64'h1234_5678_9ABC_DEF0, "R3 write2");
        rd(5, "R3 cleared2");

        // R5 trap stack at level 0
        for (int f = 0; f < 5; f++) wr(f, 64'hDEAD_0000 + 64'(f), "R5 write at tl0");
        for (int f = 0; f < 5; f++) rd(f, "R5 read at tl0");

        // R4 per-level entries
        for (int l = 1; l <= 6; l++) begin
            wr(7, 64'(l), "R4 set tl");
            for (int f = 0; f < 5; f++) wr(f, {32'(l), 32'(f) ^ 32'hA5A5_0000}, "R4 fill");
        end
        for (int l = 6; l >= 1; l--) begin
            wr(7, 64'(l), "R4 set tl");
            for (int f = 0; f < 5; f++) rd(f, "R4 readback");
        end
        wr(7, 64'd0, "R5 back to tl0");
        rd(2, "R5 entry hidden at tl0");

        // R6 clamp
        wr(7, 64'd9, "R6 write 9");
        rd(7, "R6 clamped");
        wr(7, 64'h8000_0000_0000_0003, "R6 write huge");
        rd(7, "R6 clamped huge");
        wr(7, 64'd6, "R6 write max");
        rd(7, "R6 max kept");

        // R7 trap-level-zero request
        wr(8, 64'h1, "R7 enable tlz");
        wr(7, 64'd0, "R7 raise");
        rd(9, "R7 hold on other access");
        wr(16, 64'h55, "R7 hold on other write");
        wr(7, 64'd3, "R7 drop");
        wr(8, 64'h5, "R7 hyper-privileged");
        wr(7, 64'd0, "R7 no raise when hpriv");
        wr(8, 64'h0, "R7 disable tlz");
        wr(7, 64'd0, "R7 no raise when disabled");
        wr(8, 64'h1, "R7 re-enable");
        wr(7, 64'd0, "R7 raise again");
        wr(7, 64'd0, "R7 stays raised");
        wr(7, 64'd1, "R7 drop again");

        // R8 packed context
        wr(12, 64'h0000_0000_0000_01AB, "R8 part");
        wr(13, 64'h0000_0000_0000_000C, "R8 lsu");
        wr(6, 64'h0000_0000_0000_0008, "R8 pstate");
        wr(8, 64'h0000_0000_0000_0024, "R8 hstate");
        wr(10, 64'h0000_0000_0001_2345, "R8 primary");
        wr(11, 64'h0000_0000_FFFF_ABCD, "R8 secondary");
        wr(7, 64'd5, "R8 tl");
        rd(14, "R8 packed");
        wr(14, 64'hFFFF_FFFF_FFFF_FFFF, "R8 write ignored");
        rd(14, "R8 packed unchanged");
        wr(8, 64'h0000_0000_0000_0020, "R8 hstate2");
        wr(13, 64'h0000_0000_0000_0004, "R8 lsu2");
        rd(14, "R8 packed2");

        // R9 plain storage
        for (int i = 10; i <= 13; i++) wr(i, 64'hC0DE_0000_0000_0000 | 64'(i), "R9 write ctl");
        for (int i = 16; i <= 31; i++) wr(i, {32'(i * 7), 32'hFEED_0000 + 32'(i)}, "R9 write");
        for (int i = 10; i <= 13; i++) rd(i, "R9 read ctl");
        for (int i = 16; i <= 31; i++) rd(i, "R9 read");

        // R10 unimplemented indices
        wr(15, 64'h1111, "R10 idx15 write");
        rd(15, "R10 idx15 read");
        wr(40, 64'h2222, "R10 idx40 write");
        wr(63, 64'h3333, "R10 idx63 write");
        rd(32, "R10 idx32 read");
        step(1'b0, 1'b0, 0, 64'd0, "R10 pulse ends");
        for (int i = 0; i < 32; i++) rd(i, "R10 no register changed");

        // R11 read-before-write and idle zero
        wr(20, 64'hAAAA_BBBB_CCCC_DDDD, "R11 old value returned");
        rd(20, "R11 new value visible");
        step(1'b0, 1'b1, 20, 64'h1, "R11 disabled access");
        rd(20, "R11 disabled write ignored");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule